// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block sits at the heart of a digitally modelled integer-N synthesizer loop. It takes a reference clock and an already divided feedback signal. Both are sampled on the system clock. The reference is first divided by a programmable ratio. The two rising-edge streams then drive a two-state detector that produces active-low up and down pulses for a charge pump. A pulse lasts from the earlier edge to the later one, and the detector clears itself as soon as both edges have arrived.

The up and down signals are combined by a NAND into one activity signal. A digital filter watches that activity signal in place of an external capacitor and produces a lock indicator. Lock is declared only after a programmed number of consecutive reference comparisons with no pulse longer than one clock. It is withdrawn as soon as a long pulse appears. Two monitor outputs copy the divided reference strobe and the feedback strobe, and each can be switched off by its own enable bit.

All pins are plain control and status signals. No stream flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is asserted and right after it is released, pd_up_n and pd_dn_n are 1, act is 0, lock is 0, and ref_mon and fb_mon are 0.
- R2: With ref_div_val = R, the reference divider issues one strobe on every (R+1)-th rising edge of ref_in, counted from reset, so the first strobe is on edge R+1. The strobe is visible on ref_mon for one clock, starting after the first clock edge that samples ref_in high.
- R3: When a reference strobe arrives with no feedback strobe pending, pd_up_n goes to 0 after the second clock edge that samples the reference edge. It stays 0 until the second clock edge after the feedback edge is sampled.
- R4: When a feedback strobe arrives with no reference strobe pending, pd_dn_n behaves in the same way, ending on the second clock edge after the reference edge that closes it.
- R5: Reference and feedback strobes that arrive in the same cycle produce no pulse on either output.
- R6: act equals the NAND of pd_up_n and pd_dn_n. It is 1 whenever either pulse is active.
- R7: pd_up_n and pd_dn_n are never 0 at the same time.
- R8: lock goes to 1 once lock_cycles reference strobes have been counted with no activity lasting two or more consecutive clocks. Activity lasting a single clock does not prevent lock, and lock stays 0 before the count is reached.
- R9: Activity that persists for two consecutive clocks clears lock on the next clock edge and restarts the strobe count from zero.
- R10: With mon_ref_en = 0, ref_mon stays 0, and with mon_fb_en = 0, fb_mon stays 0. A 1 on either enable passes the corresponding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock level |
| fb_in | input | 1 | Feedback (main-divider) level |
| ref_div_val | input | DIV_W | Reference divide value R; ratio is R+1 |
| lock_cycles | input | LCK_W | Clean comparisons required before lock |
| mon_ref_en | input | 1 | Enables the reference strobe monitor |
| mon_fb_en | input | 1 | Enables the feedback strobe monitor |
| pd_up_n | output | 1 | Active-low up pulse (source current) |
| pd_dn_n | output | 1 | Active-low down pulse (sink current) |
| act | output | 1 | NAND of pd_up_n and pd_dn_n |
| lock | output | 1 | 1 when locked, 0 when out of lock |
| ref_mon | output | 1 | Gated divided-reference strobe |
| fb_mon | output | 1 | Gated feedback strobe |

## Verification
The hardest state to reach is a lock that has survived activity pulses exactly one clock long and is then lost to a pulse two clocks long. The stimulus produces the short pulses by raising the feedback edge one sample after the reference edge for every comparison of the lock count. It then applies a lone reference edge whose up pulse runs on until the lock drops. Finally it counts aligned edges again to show that the count restarted from zero.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pd_pair_t;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic prev_q;
  logic rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign rise_w = sig & ~prev_q;

  generate
    if (REG_OUT) begin : g_reg
      logic rise_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= rise_w;
      end
      assign rise = rise_q;
    end else begin : g_comb
      assign rise = rise_w;
    end
  endgenerate
endmodule

// File: rtl/pfd_ref_div.sv
module pfd_ref_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_in,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (edge_in) begin
        if (cnt_q >= div_val) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign tick = tick_q;

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (cnt_q == '0));
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_ref,
  input  logic     tick_fb,
  output pd_pair_t pd
);
  logic up_q, dn_q;
  logic up_nx, dn_nx;

  always_comb begin
    up_nx = up_q | tick_ref;
    dn_nx = dn_q | tick_fb;
    if (up_nx && dn_nx) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_nx;
      dn_q <= dn_nx;
    end
  end

  assign pd.up = up_q;
  assign pd.dn = dn_q;

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));
  // R3
  up_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ref && !tick_fb && !dn_q) |=> up_q);
  // R4
  dn_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_fb && !tick_ref && !up_q) |=> dn_q);
  // R5
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_fb && tick_ref && !up_q && !dn_q) |=> (!up_q && !dn_q));
endmodule

// File: rtl/pfd_lock_filt.sv
module pfd_lock_filt #(
  parameter int LCK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             tick,
  input  logic [LCK_W-1:0] thresh,
  output logic             lock
);
  localparam logic [LCK_W-1:0] CNT_MAX = {LCK_W{1'b1}};

  logic             act_d;
  logic             long_w;
  logic [LCK_W-1:0] good_q;
  logic             lock_q;

  assign long_w = act & act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d  <= 1'b0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      act_d <= act;
      if (long_w) begin
        good_q <= '0;
        lock_q <= 1'b0;
      end else begin
        if (tick && good_q != CNT_MAX) good_q <= good_q + 1'b1;
        lock_q <= (good_q >= thresh);
      end
    end
  end

  assign lock = lock_q;

  // R9
  long_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_w |=> (!lock_q && good_q == '0));
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int LCK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [DIV_W-1:0] ref_div_val,
  input  logic [LCK_W-1:0] lock_cycles,
  input  logic             mon_ref_en,
  input  logic             mon_fb_en,
  output logic             pd_up_n,
  output logic             pd_dn_n,
  output logic             act,
  output logic             lock,
  output logic             ref_mon,
  output logic             fb_mon
);
  logic     ref_edge;
  logic     ref_tick;
  logic     fb_tick;
  pd_pair_t pd;

  pfd_edge_det #(.REG_OUT(1'b0)) ref_edge_i (
    .clk(clk), .rst_n(rst_n), .sig(ref_in), .rise(ref_edge));

  pfd_edge_det #(.REG_OUT(1'b1)) fb_edge_i (
    .clk(clk), .rst_n(rst_n), .sig(fb_in), .rise(fb_tick));

  pfd_ref_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .edge_in(ref_edge),
    .div_val(ref_div_val), .tick(ref_tick));

  pfd_core core_i (
    .clk(clk), .rst_n(rst_n), .tick_ref(ref_tick),
    .tick_fb(fb_tick), .pd(pd));

  assign pd_up_n = ~pd.up;
  assign pd_dn_n = ~pd.dn;
  assign act     = ~(pd_up_n & pd_dn_n);

  pfd_lock_filt #(.LCK_W(LCK_W)) filt_i (
    .clk(clk), .rst_n(rst_n), .act(act), .tick(ref_tick),
    .thresh(lock_cycles), .lock(lock));

  assign ref_mon = ref_tick & mon_ref_en;
  assign fb_mon  = fb_tick & mon_fb_en;

  // R3
  up_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_up_n && fb_tick) |=> pd_up_n);
endmodule

// File: tb/pfd_lock_top_tb_top.sv
module pfd_lock_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0, fb_in = 1'b0;
  logic [5:0] ref_div_val = '0;
  logic [7:0] lock_cycles = 8'd4;
  logic       mon_ref_en = 1'b1, mon_fb_en = 1'b1;
  logic       pd_up_n, pd_dn_n, act, lock, ref_mon, fb_mon;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pfd_lock_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .ref_div_val(ref_div_val), .lock_cycles(lock_cycles),
    .mon_ref_en(mon_ref_en), .mon_fb_en(mon_fb_en),
    .pd_up_n(pd_up_n), .pd_dn_n(pd_dn_n), .act(act), .lock(lock),
    .ref_mon(ref_mon), .fb_mon(fb_mon));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic edge_pair(input logic r, input logic f);
    @(negedge clk); ref_in = r; fb_in = f;
    @(negedge clk); ref_in = 1'b0; fb_in = 1'b0;
  endtask

  task automatic edge_skew();
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk); ref_in = 1'b0; fb_in = 1'b1;
    @(negedge clk); fb_in = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 up_n", pd_up_n, 1); chk("R1 dn_n", pd_dn_n, 1);
    chk("R1 act", act, 0); chk("R1 lock", lock, 0);
    chk("R1 mon", {ref_mon, fb_mon}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lock after release", lock, 0);
  endtask

  task automatic t_divide();
    ref_div_val = 6'd2; mon_ref_en = 1'b1;
    do_reset();
    for (int i = 0; i < 6; i++) begin
      edge_pair(1'b1, 1'b0);
      chk("R2 ref_mon", ref_mon, (i % 3 == 2) ? 1 : 0);
    end
    ref_div_val = 6'd0;
  endtask

  task automatic t_lead();
    do_reset();
    edge_pair(1'b1, 1'b0);
    chk("R3 up not yet", pd_up_n, 1);
    @(negedge clk);
    chk("R3 up low", pd_up_n, 0); chk("R7 dn idle", pd_dn_n, 1);
    chk("R6 act on up", act, 1);
    repeat (2) @(negedge clk);
    chk("R3 up held", pd_up_n, 0);
    edge_pair(1'b0, 1'b1);
    chk("R3 up still low", pd_up_n, 0);
    @(negedge clk);
    chk("R3 up released", pd_up_n, 1); chk("R4 no dn", pd_dn_n, 1);
    chk("R6 act idle", act, 0);
  endtask

  task automatic t_lag();
    do_reset();
    edge_pair(1'b0, 1'b1);
    @(negedge clk);
    chk("R4 dn low", pd_dn_n, 0); chk("R7 up idle", pd_up_n, 1);
    chk("R6 act on dn", act, 1);
    edge_pair(1'b1, 1'b0);
    chk("R4 dn still low", pd_dn_n, 0);
    @(negedge clk);
    chk("R4 dn released", pd_dn_n, 1); chk("R3 no up", pd_up_n, 1);
  endtask

  task automatic t_coincide();
    do_reset();
    edge_pair(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 no pulse", {pd_up_n, pd_dn_n, act}, 3'b110);
    end
  endtask

  task automatic t_lock();
    lock_cycles = 8'd4;
    do_reset();
    for (int i = 0; i < 3; i++) edge_skew();
    repeat (3) @(negedge clk);
    chk("R8 no lock before count", lock, 0);
    edge_skew();
    repeat (3) @(negedge clk);
    chk("R8 lock with short pulses", lock, 1);
    // lose lock through a long up pulse
    edge_pair(1'b1, 1'b0);
    @(negedge clk);
    chk("R9 lock held at pulse start", lock, 1);
    repeat (2) @(negedge clk);
    chk("R9 lock dropped", lock, 0);
    edge_pair(1'b0, 1'b1);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) edge_pair(1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R9 count restarted", lock, 0);
    edge_pair(1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 relock", lock, 1);
  endtask

  task automatic t_monitor();
    do_reset();
    mon_ref_en = 1'b0; mon_fb_en = 1'b0;
    edge_pair(1'b1, 1'b1);
    chk("R10 ref_mon gated", ref_mon, 0);
    chk("R10 fb_mon gated", fb_mon, 0);
    mon_ref_en = 1'b1; mon_fb_en = 1'b1;
    edge_pair(1'b1, 1'b1);
    chk("R10 ref_mon passes", ref_mon, 1);
    chk("R10 fb_mon passes", fb_mon, 1);
  endtask

  initial begin
    t_reset();
    t_divide();
    t_lead();
    t_lag();
    t_coincide();
    t_lock();
    t_monitor();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule